// File: doc/BRIEF.md
# Metastable Ring Oscillator Mode Sequencer

This block is the digital controller for a switchable inverter-ring entropy source. The ring has an odd number of stages, each with its own switch. In metastable mode every inverter is cut off from its neighbours and fed back on itself, so that it settles near its threshold voltage. In generation mode the stages are joined into a free-running ring. The controller runs repeated bit cycles. Each cycle holds the ring in metastable mode for a programmed number of clocks, then releases it into generation mode. After a short programmed delay, once the oscillation has grown to full swing, a sample strobe captures the ring output. The ring then goes straight back to metastable mode for the next bit.

The captured level passes through two synchroniser flops and is presented as one bit with a one-clock valid pulse. The cycle length, the metastable length and the sample delay are counts of system clocks. They are taken from the inputs only as the block leaves idle. A longer cycle trades throughput for a longer settling phase and lower bias. Clearing enable lets the current cycle finish, and the ring then rests in metastable mode.

Top module: `metaring_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next cycle shows `ring_join`=0 (metastable), `sample_strobe`=0 and `bit_valid`=0.
- R2: Starting from idle with `enable`=1 and an accepted configuration, the block repeats bit cycles. Each cycle is `meta_len` clocks with `ring_join`=0, followed by `cycle_len - meta_len` clocks with `ring_join`=1. The ring returns to metastable mode in the clock right after the last generation clock, and every cycle yields exactly one bit.
- R3: `sample_strobe` is high for exactly one clock per bit cycle. That clock is generation clock number `sample_dly`, counting the first generation clock as 0, so the strobe never falls on the first generation clock.
- R4: `ring_in` is captured at the clock edge that ends the strobe clock. If the strobe is high in clock c, then `bit_valid` is high for clock c+3 only, and `bit_out` then holds the captured level.
- R5: A configuration is accepted only if `meta_len` >= 1, `sample_dly` >= 1 and `sample_dly` < `cycle_len - meta_len`, with `cycle_len` > `meta_len`. If it is not accepted, the block stays idle with `ring_join`=0 and raises no strobe and no valid.
- R6: The configuration inputs are captured only at the move out of idle. Changes made to them while cycles are running have no effect on the phase lengths or on the strobe position.
- R7: When `enable` goes low during a bit cycle, that cycle completes and delivers its bit. After that, `ring_join` stays 0 until `enable` is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run request |
| cycle_len | input | CW | Total clocks per bit cycle |
| meta_len | input | CW | Clocks spent in metastable mode per cycle |
| sample_dly | input | CW | Generation clocks before the sample strobe |
| ring_in | input | 1 | Output level of the inverter ring |
| ring_join | output | 1 | 1 = stages joined into a ring (generation mode), 0 = stages self-looped (metastable mode) |
| sample_strobe | output | 1 | Capture strobe for the ring output |
| bit_out | output | 1 | Last captured bit |
| bit_valid | output | 1 | One-clock pulse marking a new bit |

## Verification
The hardest situation to reach is a configuration change that lands while cycles are already running. The inputs look idle-safe, but they must be ignored until the block parks again. The stimulus writes random values to all three configuration inputs at the first ring release of every run. It then keeps checking the phase lengths and the strobe position against the values that were loaded. Disabling in the middle of a cycle, in both the metastable phase and the generation phase, is also driven on purpose, and so is a reset during generation. In every case the bench counts the bits and ring releases that follow.

// File: rtl/metaring_sequencer.sv
module metaring_sequencer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [CW-1:0] cycle_len,
  input  logic [CW-1:0] meta_len,
  input  logic [CW-1:0] sample_dly,
  input  logic          ring_in,
  output logic          ring_join,
  output logic          sample_strobe,
  output logic          bit_out,
  output logic          bit_valid
);
  typedef enum logic [1:0] {ST_IDLE, ST_META, ST_GEN} st_t;

  st_t           st;
  logic [CW-1:0] cnt, meta_q, gen_q, dly_q;
  logic          cap, v0, d1, v1;

  wire cfg_ok = (meta_len != '0) && (sample_dly != '0) && (cycle_len > meta_len)
                && (sample_dly < (cycle_len - meta_len));

  assign ring_join     = (st == ST_GEN);
  assign sample_strobe = (st == ST_GEN) && (cnt == dly_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      meta_q <= '0;
      gen_q  <= '0;
      dly_q  <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          cnt <= '0;
          if (enable && cfg_ok) begin
            st     <= ST_META;
            meta_q <= meta_len;
            gen_q  <= cycle_len - meta_len;
            dly_q  <= sample_dly;
          end
        end
        ST_META: begin
          if (cnt == meta_q - 1'b1) begin
            st  <= ST_GEN;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          if (cnt == gen_q - 1'b1) begin
            st  <= enable ? ST_META : ST_IDLE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap <= 1'b0; v0 <= 1'b0;
      d1  <= 1'b0; v1 <= 1'b0;
      bit_out <= 1'b0; bit_valid <= 1'b0;
    end else begin
      if (sample_strobe) cap <= ring_in;
      v0        <= sample_strobe;
      d1        <= cap;
      v1        <= v0;
      bit_out   <= d1;
      bit_valid <= v1;
    end
  end

  assert_reset_parks_R1: assert property (@(posedge clk)
    !rst_n |=> (!ring_join && !sample_strobe && !bit_valid));

  assert_strobe_after_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |-> (ring_join && $past(ring_join)));

  assert_valid_after_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> $past(sample_strobe, 3));

  assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid);

  assert_parked_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !ring_join && $past(!ring_join) && !$past(enable)) |=> !ring_join || $past(st == ST_META));
endmodule

// File: tb/metaring_sequencer_test.sv
module metaring_sequencer_test;
  localparam int CW = 8;
  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, ring_in = 1'b0;
  logic [CW-1:0] cycle_len = '0, meta_len = '0, sample_dly = '0;
  logic ring_join, sample_strobe, bit_out, bit_valid;
  int checks = 0, errors = 0, ticks = 0;

  metaring_sequencer #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cycle_len(cycle_len),
    .meta_len(meta_len), .sample_dly(sample_dly), .ring_in(ring_in),
    .ring_join(ring_join), .sample_strobe(sample_strobe),
    .bit_out(bit_out), .bit_valid(bit_valid));

  always #4 clk = ~clk;

  always @(posedge ring_join) ring_in <= 1'($urandom_range(1, 0));

  always @(posedge clk) begin
    ticks++;
    if (ticks > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", ticks);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_cfg(input int cyc, input int meta, input int dly, input int nbits);
    int got = 0, genlen = 0, lowlen = 0, cd = 0, n = 0;
    bit prev = 0, seen = 0, scr = 0;
    logic expbit = 0;
    @(negedge clk);
    cycle_len = CW'(cyc); meta_len = CW'(meta); sample_dly = CW'(dly); enable = 1'b1;
    while (got < nbits && n < 4000) begin
      @(negedge clk); n++;
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin
          check(bit_valid == 1'b1, "R4 valid three clocks after strobe", int'(bit_valid), 1);
          check(bit_out == expbit, "R4 captured bit", int'(bit_out), int'(expbit));
          got++;
        end else check(bit_valid == 1'b0, "R4 early valid", int'(bit_valid), 0);
      end else if (bit_valid) check(0, "R4 stray valid", 1, 0);
      if (ring_join) begin
        if (!prev) begin
          if (seen) check(lowlen == meta, "R2 metastable length", lowlen, meta);
          seen = 1; genlen = 0;
          if (!scr) begin
            cycle_len = CW'($urandom); meta_len = CW'($urandom); sample_dly = CW'($urandom);
            scr = 1;
          end
        end
        genlen++;
      end else begin
        if (prev) begin
          check(genlen == cyc - meta, "R2 R6 generation length", genlen, cyc - meta);
          lowlen = 0;
        end
        lowlen++;
      end
      if (sample_strobe) begin
        check(ring_join && genlen == dly + 1, "R3 R6 strobe position", genlen, dly + 1);
        cd = 3; expbit = ring_in;
      end
      prev = ring_join;
    end
    check(got == nbits, "R2 one bit per cycle", got, nbits);
    enable = 1'b0;
    repeat (2 * cyc + 8) @(negedge clk);
  endtask

  task automatic reject(input int cyc, input int meta, input int dly);
    int highs = 0, strobes = 0, vals = 0;
    @(negedge clk);
    cycle_len = CW'(cyc); meta_len = CW'(meta); sample_dly = CW'(dly); enable = 1'b1;
    repeat (40) begin
      @(negedge clk);
      highs += int'(ring_join); strobes += int'(sample_strobe); vals += int'(bit_valid);
    end
    check(highs == 0 && strobes == 0 && vals == 0, "R5 rejected config stays idle", highs + strobes + vals, 0);
    enable = 1'b0;
    @(negedge clk);
  endtask

  task automatic stop_mid(input bit in_gen);
    int vals = 0, late = 0;
    @(negedge clk);
    cycle_len = 8'd7; meta_len = 8'd3; sample_dly = 8'd2; enable = 1'b1;
    if (in_gen) @(posedge ring_join);
    @(negedge clk);
    enable = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      vals += int'(bit_valid);
      if (i >= 12) late += int'(ring_join);
    end
    check(vals == 1, "R7 current cycle delivers its bit", vals, 1);
    check(late == 0, "R7 parked in metastable mode", late, 0);
  endtask

  initial begin
    void'($urandom(32'd11));
    repeat (3) @(negedge clk);
    check(!ring_join && !sample_strobe && !bit_valid, "R1 reset state",
          int'(ring_join) + int'(sample_strobe) + int'(bit_valid), 0);
    rst_n = 1'b1;
    run_cfg(3, 1, 1, 6);
    run_cfg(12, 4, 7, 5);
    run_cfg(20, 10, 3, 4);
    run_cfg(9, 2, 6, 5);
    for (int k = 0; k < 8; k++) begin
      int m = $urandom_range(6, 1);
      int g = $urandom_range(9, 2);
      int d = $urandom_range(g - 1, 1);
      run_cfg(m + g, m, d, 4);
    end
    reject(5, 2, 3);
    reject(6, 0, 2);
    reject(6, 2, 0);
    reject(4, 4, 1);
    reject(9, 2, 9);
    stop_mid(1'b0);
    stop_mid(1'b1);
    @(negedge clk);
    cycle_len = 8'd8; meta_len = 8'd3; sample_dly = 8'd2; enable = 1'b1;
    @(posedge ring_join);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!ring_join && !sample_strobe && !bit_valid, "R1 reset during generation",
          int'(ring_join) + int'(sample_strobe) + int'(bit_valid), 0);
    rst_n = 1'b1;
    enable = 1'b0;
    repeat (20) @(negedge clk);
    run_cfg(8, 3, 2, 3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule